// File: doc/BRIEF.md
# Circular Display Pixel FIFO

This block is a small ring of pixel words that sits between a memory-side writer (a processor or a DMA engine) and the display path. The writer pushes pixels through a two-offset register window: a halfword at the low offset, a halfword at the high offset, or one full 32-bit word covering both. Pixels are always placed as a pair of adjacent ring slots, and only the upper half of the pair moves the write pointer. The display side pops one pixel per strobe and drops it straight into a scanline buffer at a burst offset plus a running index.

The ring has no occupancy tracking. A writer that runs ahead of the reader overwrites old entries, and a reader that catches up with the writer keeps reading whatever is stored. Both pointers return to slot zero at vertical blank, so each frame starts from a known alignment. The display side sets a new burst base when it starts a group of pixels, and reads the scanline buffer through an address-in, data-out port.

Top module: `scan_pixel_ring`

## Requirements
- R1: While `rst_n` is low, both ring pointers are 0, every ring slot holds 0 and every scanline-buffer entry holds 0.
- R2: A halfword write at the low offset (`wr_en`=1, `wr_word`=0, `wr_hi`=0) stores `wr_data[15:0]` in the slot at the write pointer and leaves the write pointer unchanged; a second such write replaces the first.
- R3: A halfword write at the high offset (`wr_en`=1, `wr_word`=0, `wr_hi`=1) stores `wr_data[15:0]` in the slot at write pointer + 1 and then adds 2 to the write pointer.
- R4: A word write (`wr_en`=1, `wr_word`=1, `wr_hi` ignored) stores `wr_data[15:0]` at the write pointer and `wr_data[31:16]` at write pointer + 1, then adds 2 to the write pointer.
- R5: `pop_data` always shows the slot at the read pointer; a `pop` strobe consumes that slot and adds 1 to the read pointer. With equal pointers the stored value is still returned, with no empty indication.
- R6: All pointer arithmetic wraps modulo 16, so writes beyond 16 pixels ahead of the reader overwrite the oldest slots with no full indication.
- R7: A cycle with `vblank` high sets both pointers to 0 on the next edge; any write and any pop in that same cycle are dropped (no slot, pointer or scanline entry changes).
- R8: A write and a pop in the same cycle both act on the pointer values from before that edge; if the pop reads the slot being written, it returns the old content and the new value lands afterwards.
- R9: Each popped pixel is written into the 256-entry scanline buffer at burst base + index within the burst, modulo 256; `burst_start` loads `burst_offset` as the new base with index 0, and a pop in the same cycle as `burst_start` writes to `burst_offset` itself.
- R10: `lb_rdata` shows the scanline-buffer entry at `lb_raddr` in the same cycle, with no latency.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| vblank | input | 1 | Vertical-blank strobe; clears both pointers |
| wr_en | input | 1 | Register-window write strobe |
| wr_word | input | 1 | 1 = full 32-bit write, 0 = halfword write |
| wr_hi | input | 1 | For halfword writes: 0 = low offset, 1 = high offset |
| wr_data | input | 32 | Write data; halfword writes use bits 15:0 |
| pop | input | 1 | Display-side pop strobe |
| burst_start | input | 1 | Loads a new scanline burst base |
| burst_offset | input | 8 | Scanline position of the first pixel of a burst |
| pop_data | output | 16 | Slot at the read pointer |
| wr_ptr | output | 4 | Current write pointer |
| rd_ptr | output | 4 | Current read pointer |
| lb_raddr | input | 8 | Scanline buffer read address |
| lb_rdata | output | 16 | Scanline buffer read data |

## Verification
A writer push and a display pop can fall in the same cycle, and the ring must then resolve both against the old pointers. The bench provokes this in the vector table with a word write alongside a pop, and again directly with both pointers at zero, so that the pop reads the very slot the low-offset write replaces. It judges the pop value sampled before the edge against the old slot content, then checks that the new value appears when the read pointer comes back around after a vertical blank.

// File: rtl/spr_pkg.sv
package spr_pkg;

  // What one register-window access does to the ring this cycle.
  typedef enum logic [1:0] {
    WK_NONE = 2'd0,
    WK_LO   = 2'd1,
    WK_HI   = 2'd2,
    WK_WORD = 2'd3
  } wr_kind_e;

  // Classify a window access; vertical blank wins over everything.
  function automatic wr_kind_e decode_wr(input logic en, input logic word,
                                         input logic hi, input logic blank);
    wr_kind_e k;
    if (!en || blank)  k = WK_NONE;
    else if (word)     k = WK_WORD;
    else if (hi)       k = WK_HI;
    else               k = WK_LO;
    return k;
  endfunction

  // Slot at the write pointer receives data for these kinds.
  function automatic logic kind_uses_base(input wr_kind_e k);
    return (k == WK_LO) || (k == WK_WORD);
  endfunction

  // Slot one past the write pointer receives data for these kinds.
  function automatic logic kind_uses_pair(input wr_kind_e k);
    return (k == WK_HI) || (k == WK_WORD);
  endfunction

  // Pointer step in slots: only the upper half of a pair advances.
  function automatic logic [1:0] kind_step(input wr_kind_e k);
    return kind_uses_pair(k) ? 2'd2 : 2'd0;
  endfunction

endpackage

// File: rtl/spr_wr_ctrl.sv
module spr_wr_ctrl #(
  parameter int PIX_W = 16,
  parameter int PTR_W = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               vblank,
  input  logic               wr_en,
  input  logic               wr_word,
  input  logic               wr_hi,
  input  logic [2*PIX_W-1:0] wr_data,
  output spr_pkg::wr_kind_e  wr_kind,
  output logic               slot_a_we,
  output logic [PTR_W-1:0]   slot_a_idx,
  output logic [PIX_W-1:0]   slot_a_dat,
  output logic               slot_b_we,
  output logic [PTR_W-1:0]   slot_b_idx,
  output logic [PIX_W-1:0]   slot_b_dat,
  output logic [PTR_W-1:0]   wr_ptr
);
  import spr_pkg::*;

  logic [PTR_W-1:0] wp_q;

  function automatic logic [PTR_W-1:0] ptr_add(input logic [PTR_W-1:0] p,
                                               input logic [1:0] s);
    return p + PTR_W'(s);
  endfunction

  always_comb begin
    wr_kind    = decode_wr(wr_en, wr_word, wr_hi, vblank);
    slot_a_we  = kind_uses_base(wr_kind);
    slot_b_we  = kind_uses_pair(wr_kind);
    slot_a_idx = wp_q;
    slot_b_idx = ptr_add(wp_q, 2'd1);
    slot_a_dat = wr_data[PIX_W-1:0];
    // High-offset halfwords arrive on the low lane of the bus.
    slot_b_dat = (wr_kind == WK_WORD) ? wr_data[2*PIX_W-1:PIX_W]
                                      : wr_data[PIX_W-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      wp_q <= '0;
    else if (vblank) wp_q <= '0;
    else             wp_q <= ptr_add(wp_q, kind_step(wr_kind));
  end

  assign wr_ptr = wp_q;

endmodule

// File: rtl/spr_rd_ctrl.sv
module spr_rd_ctrl #(
  parameter int PTR_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             vblank,
  input  logic             pop,
  output logic             pop_fire,
  output logic [PTR_W-1:0] rd_ptr
);
  logic [PTR_W-1:0] rp_q;

  function automatic logic [PTR_W-1:0] ptr_inc(input logic [PTR_W-1:0] p);
    return p + PTR_W'(1);
  endfunction

  assign pop_fire = pop && !vblank;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        rp_q <= '0;
    else if (vblank)   rp_q <= '0;
    else if (pop_fire) rp_q <= ptr_inc(rp_q);
  end

  assign rd_ptr = rp_q;

endmodule

// File: rtl/spr_store.sv
module spr_store #(
  parameter int PIX_W = 16,
  parameter int DEPTH = 16,
  localparam int PTR_W = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             a_we,
  input  logic [PTR_W-1:0] a_idx,
  input  logic [PIX_W-1:0] a_dat,
  input  logic             b_we,
  input  logic [PTR_W-1:0] b_idx,
  input  logic [PIX_W-1:0] b_dat,
  input  logic [PTR_W-1:0] r_idx,
  output logic [PIX_W-1:0] r_dat
);
  logic [PIX_W-1:0] slots [DEPTH];

  // The two write lanes always address neighbouring slots, never the same one.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) slots[i] <= '0;
    end else begin
      if (a_we) slots[a_idx] <= a_dat;
      if (b_we) slots[b_idx] <= b_dat;
    end
  end

  // Read before write: a same-cycle pop sees the old content.
  assign r_dat = slots[r_idx];

endmodule

// File: rtl/spr_line_buf.sv
module spr_line_buf #(
  parameter int PIX_W    = 16,
  parameter int LINE_LEN = 256,
  localparam int LB_AW   = $clog2(LINE_LEN)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             pop_fire,
  input  logic [PIX_W-1:0] pix_in,
  input  logic             burst_start,
  input  logic [LB_AW-1:0] burst_offset,
  input  logic [LB_AW-1:0] lb_raddr,
  output logic [PIX_W-1:0] lb_rdata,
  output logic             lb_we,
  output logic [LB_AW-1:0] lb_waddr,
  output logic [LB_AW-1:0] fill_idx
);
  logic [LB_AW-1:0] base_q;
  logic [LB_AW-1:0] idx_q;
  logic [PIX_W-1:0] line [LINE_LEN];

  function automatic logic [LB_AW-1:0] fill_addr(input logic [LB_AW-1:0] b,
                                                 input logic [LB_AW-1:0] i);
    return b + i;
  endfunction

  always_comb begin
    lb_we    = pop_fire;
    lb_waddr = burst_start ? burst_offset : fill_addr(base_q, idx_q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      base_q <= '0;
      idx_q  <= '0;
    end else if (burst_start) begin
      base_q <= burst_offset;
      idx_q  <= pop_fire ? LB_AW'(1) : '0;
    end else if (pop_fire) begin
      idx_q  <= idx_q + LB_AW'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < LINE_LEN; i++) line[i] <= '0;
    end else if (lb_we) begin
      line[lb_waddr] <= pix_in;
    end
  end

  assign lb_rdata = line[lb_raddr];
  assign fill_idx = idx_q;

endmodule

// File: rtl/scan_pixel_ring.sv
module scan_pixel_ring #(
  parameter int PIX_W    = 16,
  parameter int DEPTH    = 16,
  parameter int LINE_LEN = 256,
  localparam int PTR_W   = $clog2(DEPTH),
  localparam int LB_AW   = $clog2(LINE_LEN),
  localparam int BUS_W   = 2 * PIX_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             vblank,
  input  logic             wr_en,
  input  logic             wr_word,
  input  logic             wr_hi,
  input  logic [BUS_W-1:0] wr_data,
  input  logic             pop,
  input  logic             burst_start,
  input  logic [LB_AW-1:0] burst_offset,
  output logic [PIX_W-1:0] pop_data,
  output logic [PTR_W-1:0] wr_ptr,
  output logic [PTR_W-1:0] rd_ptr,
  input  logic [LB_AW-1:0] lb_raddr,
  output logic [PIX_W-1:0] lb_rdata
);
  import spr_pkg::*;

  // Internal events, named for the checker.
  wr_kind_e         wr_kind;
  logic             slot_a_we, slot_b_we;
  logic [PTR_W-1:0] slot_a_idx, slot_b_idx;
  logic [PIX_W-1:0] slot_a_dat, slot_b_dat;
  logic             pop_fire;
  logic             lb_we;
  logic [LB_AW-1:0] lb_waddr;
  logic [LB_AW-1:0] fill_idx;

  spr_wr_ctrl #(.PIX_W(PIX_W), .PTR_W(PTR_W)) u_wr (
    .clk        (clk),
    .rst_n      (rst_n),
    .vblank     (vblank),
    .wr_en      (wr_en),
    .wr_word    (wr_word),
    .wr_hi      (wr_hi),
    .wr_data    (wr_data),
    .wr_kind    (wr_kind),
    .slot_a_we  (slot_a_we),
    .slot_a_idx (slot_a_idx),
    .slot_a_dat (slot_a_dat),
    .slot_b_we  (slot_b_we),
    .slot_b_idx (slot_b_idx),
    .slot_b_dat (slot_b_dat),
    .wr_ptr     (wr_ptr)
  );

  spr_rd_ctrl #(.PTR_W(PTR_W)) u_rd (
    .clk      (clk),
    .rst_n    (rst_n),
    .vblank   (vblank),
    .pop      (pop),
    .pop_fire (pop_fire),
    .rd_ptr   (rd_ptr)
  );

  spr_store #(.PIX_W(PIX_W), .DEPTH(DEPTH)) u_store (
    .clk   (clk),
    .rst_n (rst_n),
    .a_we  (slot_a_we),
    .a_idx (slot_a_idx),
    .a_dat (slot_a_dat),
    .b_we  (slot_b_we),
    .b_idx (slot_b_idx),
    .b_dat (slot_b_dat),
    .r_idx (rd_ptr),
    .r_dat (pop_data)
  );

  spr_line_buf #(.PIX_W(PIX_W), .LINE_LEN(LINE_LEN)) u_line (
    .clk          (clk),
    .rst_n        (rst_n),
    .pop_fire     (pop_fire),
    .pix_in       (pop_data),
    .burst_start  (burst_start),
    .burst_offset (burst_offset),
    .lb_raddr     (lb_raddr),
    .lb_rdata     (lb_rdata),
    .lb_we        (lb_we),
    .lb_waddr     (lb_waddr),
    .fill_idx     (fill_idx)
  );

endmodule

// File: rtl/spr_check.sv
module spr_check #(
  parameter int PTR_W = 4,
  parameter int LB_AW = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             vblank,
  input logic             wr_en,
  input logic             wr_word,
  input logic             wr_hi,
  input logic             pop,
  input logic             burst_start,
  input logic [PTR_W-1:0] wr_ptr,
  input logic [PTR_W-1:0] rd_ptr,
  input logic             lb_we,
  input logic [LB_AW-1:0] fill_idx
);

  // R1: reset forces both pointers home
  assert_reset_home_R1: assert property (@(posedge clk)
    !rst_n |=> (wr_ptr == '0) && (rd_ptr == '0));

  // R2: low-offset halfword leaves the write pointer in place
  assert_lo_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !wr_word && !wr_hi && !vblank) |=> $stable(wr_ptr));

  // R3 / R4: pair-completing writes step the write pointer by two
  assert_pair_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && (wr_word || wr_hi) && !vblank)
      |=> wr_ptr == $past(wr_ptr) + PTR_W'(2));

  // R5: each pop steps the read pointer by one
  assert_pop_step_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (pop && !vblank) |=> rd_ptr == $past(rd_ptr) + PTR_W'(1));

  // R5: no pop, no movement
  assert_rd_idle_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!pop && !vblank) |=> $stable(rd_ptr));

  // R7: vertical blank homes both pointers
  assert_blank_home_R7: assert property (@(posedge clk) disable iff (!rst_n)
    vblank |=> (wr_ptr == '0) && (rd_ptr == '0));

  // R7: no scanline write during vertical blank
  assert_blank_no_fill_R7: assert property (@(posedge clk) disable iff (!rst_n)
    vblank |-> !lb_we);

  // R9: fill index counts pops within a burst
  assert_fill_step_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (pop && !vblank && !burst_start) |=> fill_idx == $past(fill_idx) + LB_AW'(1));

  // R9: a fresh burst with no pop starts at index zero
  assert_burst_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (burst_start && !(pop && !vblank)) |=> fill_idx == '0);

endmodule

bind scan_pixel_ring spr_check #(.PTR_W(PTR_W), .LB_AW(LB_AW)) u_spr_check (
  .clk         (clk),
  .rst_n       (rst_n),
  .vblank      (vblank),
  .wr_en       (wr_en),
  .wr_word     (wr_word),
  .wr_hi       (wr_hi),
  .pop         (pop),
  .burst_start (burst_start),
  .wr_ptr      (wr_ptr),
  .rd_ptr      (rd_ptr),
  .lb_we       (lb_we),
  .fill_idx    (fill_idx)
);

// File: tb/test_scan_pixel_ring.sv
`timescale 1ns/1ps
module test_scan_pixel_ring;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        vblank = 1'b0;
  logic        wr_en = 1'b0, wr_word = 1'b0, wr_hi = 1'b0;
  logic [31:0] wr_data = '0;
  logic        pop = 1'b0;
  logic        burst_start = 1'b0;
  logic [7:0]  burst_offset = '0;
  logic [15:0] pop_data;
  logic [3:0]  wr_ptr, rd_ptr;
  logic [7:0]  lb_raddr = '0;
  logic [15:0] lb_rdata;

  int n_run = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  scan_pixel_ring i_scan_pixel_ring (
    .clk(clk), .rst_n(rst_n), .vblank(vblank),
    .wr_en(wr_en), .wr_word(wr_word), .wr_hi(wr_hi), .wr_data(wr_data),
    .pop(pop), .burst_start(burst_start), .burst_offset(burst_offset),
    .pop_data(pop_data), .wr_ptr(wr_ptr), .rd_ptr(rd_ptr),
    .lb_raddr(lb_raddr), .lb_rdata(lb_rdata)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual %h expected %h", tag, act, exp);
    end
  endtask

  // One cycle: drive at a falling edge, sample pop_data before the rising
  // edge, return at the next falling edge with inputs idle again.
  task automatic step(input logic we, input logic word, input logic hi,
                      input logic [31:0] d, input logic p, input logic bs,
                      input logic [7:0] bo, input logic vb,
                      output logic [15:0] pre_pop);
    wr_en = we; wr_word = word; wr_hi = hi; wr_data = d;
    pop = p; burst_start = bs; burst_offset = bo; vblank = vb;
    #1;
    pre_pop = pop_data;
    @(negedge clk);
    wr_en = 1'b0; wr_word = 1'b0; wr_hi = 1'b0; wr_data = '0;
    pop = 1'b0; burst_start = 1'b0; burst_offset = '0; vblank = 1'b0;
  endtask

  task automatic lb_peek(input logic [7:0] a, output logic [15:0] v);
    lb_raddr = a;
    #0.5;
    v = lb_rdata;
  endtask

  // Vector: {req[3:0], we, word, hi, data[31:0], pop, chk, exp_pop[15:0], ewp[3:0], erp[3:0]}
  localparam int NV = 11;
  localparam logic [64:0] VEC [NV] = '{
    {4'd4, 1'b1,1'b1,1'b0, 32'hBBBB_AAAA, 1'b0,1'b0, 16'h0000, 4'd2, 4'd0}, // R4 word
    {4'd2, 1'b1,1'b0,1'b0, 32'h0000_1111, 1'b0,1'b0, 16'h0000, 4'd2, 4'd0}, // R2 low
    {4'd2, 1'b1,1'b0,1'b0, 32'h0000_2222, 1'b0,1'b0, 16'h0000, 4'd2, 4'd0}, // R2 replace
    {4'd3, 1'b1,1'b0,1'b1, 32'h0000_3333, 1'b0,1'b0, 16'h0000, 4'd4, 4'd0}, // R3 high
    {4'd5, 1'b0,1'b0,1'b0, 32'h0,         1'b1,1'b1, 16'hAAAA, 4'd4, 4'd1}, // R5
    {4'd5, 1'b0,1'b0,1'b0, 32'h0,         1'b1,1'b1, 16'hBBBB, 4'd4, 4'd2}, // R5
    {4'd8, 1'b1,1'b1,1'b0, 32'h5555_4444, 1'b1,1'b1, 16'h2222, 4'd6, 4'd3}, // R8 both
    {4'd3, 1'b0,1'b0,1'b0, 32'h0,         1'b1,1'b1, 16'h3333, 4'd6, 4'd4}, // R3 data
    {4'd4, 1'b0,1'b0,1'b0, 32'h0,         1'b1,1'b1, 16'h4444, 4'd6, 4'd5}, // R4 data
    {4'd4, 1'b0,1'b0,1'b0, 32'h0,         1'b1,1'b1, 16'h5555, 4'd6, 4'd6}, // R4 data
    {4'd5, 1'b0,1'b0,1'b0, 32'h0,         1'b1,1'b1, 16'h0000, 4'd6, 4'd7}  // R5 equal ptrs
  };

  initial begin
    #(5.0 * 150000);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    logic [15:0] pv, lv;
    repeat (3) @(negedge clk);
    // R1: reset state
    check("R1 wr_ptr", {28'd0, wr_ptr}, 32'd0);
    check("R1 rd_ptr", {28'd0, rd_ptr}, 32'd0);
    check("R1 pop_data", {16'd0, pop_data}, 32'd0);
    lb_peek(8'd200, lv);
    check("R1 line", {16'd0, lv}, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);

    for (int i = 0; i < NV; i++) begin
      logic [64:0] v;
      v = VEC[i];
      step(v[60], v[59], v[58], v[57:26], v[25], 1'b0, 8'd0, 1'b0, pv);
      if (v[24]) begin
        n_run++;
        if (pv !== v[23:8]) begin
          n_fail++;
          $display("FAIL R%0d vec %0d pop actual %h expected %h", v[64:61], i, pv, v[23:8]);
        end
      end
      n_run++;
      if (wr_ptr !== v[7:4] || rd_ptr !== v[3:0]) begin
        n_fail++;
        $display("FAIL R%0d vec %0d ptrs actual %0d/%0d expected %0d/%0d",
                 v[64:61], i, wr_ptr, rd_ptr, v[7:4], v[3:0]);
      end
    end

    // R7: vertical blank homes both pointers
    step(1'b0, 1'b0, 1'b0, 32'h0, 1'b0, 1'b0, 8'd0, 1'b1, pv);
    check("R7 wr_ptr", {28'd0, wr_ptr}, 32'd0);
    check("R7 rd_ptr", {28'd0, rd_ptr}, 32'd0);

    // R6: nine words wrap the ring and overwrite slots 0 and 1
    for (int k = 0; k < 9; k++)
      step(1'b1, 1'b1, 1'b0, {16'h1000 + 16'(2*k+1), 16'h1000 + 16'(2*k)},
           1'b0, 1'b0, 8'd0, 1'b0, pv);
    check("R6 wr_ptr wrap", {28'd0, wr_ptr}, 32'd2);
    for (int k = 0; k < 17; k++) begin
      logic [15:0] e;
      int s;
      s = k % 16;
      e = (s < 2) ? 16'h1010 + 16'(s) : 16'h1000 + 16'(s);
      step(1'b0, 1'b0, 1'b0, 32'h0, 1'b1, 1'b0, 8'd0, 1'b0, pv);
      check($sformatf("R6 pop %0d", k), {16'd0, pv}, {16'd0, e});
    end
    check("R6 rd_ptr wrap", {28'd0, rd_ptr}, 32'd1);

    // R8: pop and low write on the same slot
    step(1'b0, 1'b0, 1'b0, 32'h0, 1'b0, 1'b0, 8'd0, 1'b1, pv);
    step(1'b1, 1'b0, 1'b0, 32'h0000_DEAD, 1'b1, 1'b0, 8'd0, 1'b0, pv);
    check("R8 pop old", {16'd0, pv}, 32'h1010);
    check("R8 ptrs", {24'd0, wr_ptr, rd_ptr}, {24'd0, 4'd0, 4'd1});
    step(1'b0, 1'b0, 1'b0, 32'h0, 1'b0, 1'b0, 8'd0, 1'b1, pv);
    check("R8 new landed", {16'd0, pop_data}, 32'hDEAD);

    // R7: write and pop during vertical blank are dropped
    step(1'b1, 1'b1, 1'b0, 32'hFFFF_EEEE, 1'b1, 1'b0, 8'd0, 1'b1, pv);
    check("R7 ptrs", {24'd0, wr_ptr, rd_ptr}, 32'd0);
    check("R7 slot0 kept", {16'd0, pop_data}, 32'hDEAD);
    step(1'b0, 1'b0, 1'b0, 32'h0, 1'b1, 1'b0, 8'd0, 1'b0, pv);
    check("R7 slot1 kept", {16'd0, pop_data}, 32'h1011);

    // R9: burst at 254 wraps across the end of the line
    step(1'b0, 1'b0, 1'b0, 32'h0, 1'b0, 1'b0, 8'd0, 1'b1, pv);
    step(1'b0, 1'b0, 1'b0, 32'h0, 1'b0, 1'b1, 8'd254, 1'b0, pv);
    for (int k = 0; k < 3; k++)
      step(1'b0, 1'b0, 1'b0, 32'h0, 1'b1, 1'b0, 8'd0, 1'b0, pv);
    // R10: same-cycle read of the scanline buffer
    lb_peek(8'd254, lv); check("R10 line 254", {16'd0, lv}, 32'hDEAD);
    lb_peek(8'd255, lv); check("R9 line 255", {16'd0, lv}, 32'h1011);
    lb_peek(8'd0,   lv); check("R9 line 0 wrap", {16'd0, lv}, 32'h1002);
    // R9: burst start and pop together write at the new base
    step(1'b0, 1'b0, 1'b0, 32'h0, 1'b1, 1'b1, 8'd10, 1'b0, pv);
    step(1'b0, 1'b0, 1'b0, 32'h0, 1'b1, 1'b0, 8'd0, 1'b0, pv);
    lb_peek(8'd10, lv); check("R9 line 10", {16'd0, lv}, 32'h1003);
    lb_peek(8'd11, lv); check("R9 line 11", {16'd0, lv}, 32'h1004);

    // R1: reset again clears ring and scanline buffer
    rst_n = 1'b0;
    @(negedge clk);
    check("R1 reset ptrs", {24'd0, wr_ptr, rd_ptr}, 32'd0);
    check("R1 reset slot", {16'd0, pop_data}, 32'd0);
    lb_peek(8'd254, lv); check("R1 reset line", {16'd0, lv}, 32'd0);

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule